// File: doc/BRIEF.md
# Correctable Error Location Bitmap

This block keeps a one-bit-per-combination record of corrected memory errors. The correction datapath raises a single-cycle error pulse together with the 5-bit syndrome, the bank bit and the four most significant address bits of the failing word. The block packs these fields into a 10-bit index and sets the bit at that index in a 1024-entry bitmap. No data words are stored. The position of each set bit tells which syndrome occurred, which also gives the failing bit and chip, and in which bank and address region it occurred.

Maintenance logic reaches the bitmap through a single-entry port. That port only works while the refresh-slot strobe is high, so it never competes with normal memory cycles. A read returns one bit, registered, on the following cycle. A write stores one bit. Writing zeros to every entry clears the log after a full readout so that repeated errors are caught again. Writing saved contents back reloads the log.

Top module: `err_log_map`

## Requirements
- R1: After reset every bitmap entry is 0, `rd_valid` is 0 and `rd_bit` is 0.
- R2: An error pulse sets the entry at index `{err_syn[4:0], err_bank, err_msb[3:0]}` (that is, syn*32 + bank*16 + msb) to 1 and leaves every other entry unchanged. A repeated error at a set entry leaves it at 1.
- R3: When `port_rd` and `rfsh_slot` are both high at a clock edge, `rd_valid` is 1 and `rd_bit` holds the entry at `port_addr` during the following cycle.
- R4: A read request without `rfsh_slot` is ignored: `rd_valid` stays 0 and `rd_bit` keeps its previous value.
- R5: When `port_wr` and `rfsh_slot` are both high at a clock edge, the entry at `port_addr` takes `port_wdata`. A 0 clears the entry and a 1 sets it.
- R6: A write request without `rfsh_slot` is ignored, and the addressed entry keeps its value.
- R7: If an error and a port write hit the same index in the same cycle, the entry ends at 1. A port write to a different index in that cycle still takes effect.
- R8: Errors are recorded whatever the state of `rfsh_slot`.
- R9: A read and a write to the same index in one refresh slot return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse | input | 1 | Corrected-error strobe, one cycle per error |
| err_syn | input | 5 | Syndrome of the corrected error |
| err_bank | input | 1 | Bank of the failing word |
| err_msb | input | 4 | Four most significant address bits of the failing word |
| rfsh_slot | input | 1 | High during refresh slots; enables the port |
| port_addr | input | 10 | Bitmap index for port read or write |
| port_rd | input | 1 | Port read request |
| port_wr | input | 1 | Port write request |
| port_wdata | input | 1 | Bit to write |
| rd_bit | output | 1 | Registered read result |
| rd_valid | output | 1 | High for one cycle when `rd_bit` carries a fresh read |

## Verification
Every result appears one clock edge after its request. A port read sampled at an edge shows on `rd_bit`/`rd_valid` in the cycle that follows. An error or port write sampled at an edge can be seen by a read request issued in the next cycle, so its result arrives two edges after the stimulus. The bench drives inputs on falling edges and samples outputs on the falling edge one cycle after each request. It keeps a 1024-entry model in which every index is computed arithmetically from syndrome, bank and region, and compares the whole bitmap against that model after each phase.

// File: rtl/elog_pkg.sv
package elog_pkg;

    // Default field widths of the error descriptor
    localparam int SYN_W_DEF = 5;
    localparam int MSB_W_DEF = 4;

    // Decoded request on the maintenance port
    typedef enum logic [1:0] {
        POP_IDLE  = 2'd0,
        POP_READ  = 2'd1,
        POP_WRITE = 2'd2,
        POP_RDWR  = 2'd3
    } port_op_e;

endpackage

// File: rtl/elog_addr_form.sv
module elog_addr_form #(
    parameter int SYN_W = elog_pkg::SYN_W_DEF,
    parameter int MSB_W = elog_pkg::MSB_W_DEF,
    localparam int AW   = SYN_W + 1 + MSB_W
) (
    input  logic             err_pulse,
    input  logic [SYN_W-1:0] err_syn,
    input  logic             err_bank,
    input  logic [MSB_W-1:0] err_msb,
    output logic             err_we,
    output logic [AW-1:0]    err_addr
);

    // Syndrome in the upper bits, then bank, then address region
    always_comb begin
        err_we   = err_pulse;
        err_addr = {err_syn, err_bank, err_msb};
    end

endmodule

// File: rtl/elog_port_ctl.sv
module elog_port_ctl
    import elog_pkg::*;
(
    input  logic rfsh_slot,
    input  logic port_rd,
    input  logic port_wr,
    output logic rd_en,
    output logic wr_en
);

    port_op_e op;

    // Requests outside a refresh slot decode to idle
    always_comb begin
        op = POP_IDLE;
        if (rfsh_slot) begin
            unique case ({port_wr, port_rd})
                2'b01:   op = POP_READ;
                2'b10:   op = POP_WRITE;
                2'b11:   op = POP_RDWR;
                default: op = POP_IDLE;
            endcase
        end
        rd_en = (op == POP_READ) || (op == POP_RDWR);
        wr_en = (op == POP_WRITE) || (op == POP_RDWR);
    end

endmodule

// File: rtl/elog_array.sv
module elog_array #(
    parameter int AW    = 10,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          err_we,
    input  logic [AW-1:0] err_addr,
    input  logic          port_we,
    input  logic          port_rd,
    input  logic [AW-1:0] port_addr,
    input  logic          port_wdata,
    output logic          rd_bit,
    output logic          rd_valid
);

    typedef struct packed {
        logic [DEPTH-1:0] bits;
        logic             rdata;
        logic             rvalid;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = port_rd;
        if (port_rd) begin
            st_d.rdata = st_q.bits[port_addr];
        end
        if (port_we) begin
            st_d.bits[port_addr] = port_wdata;
        end
        // Error write applied last so it overrides a same-index port write
        if (err_we) begin
            st_d.bits[err_addr] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_bit   = st_q.rdata;
    assign rd_valid = st_q.rvalid;

    AST_ERR_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        err_we |=> st_q.bits[$past(err_addr)]);  // R2

    AST_PORT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (port_we && !(err_we && err_addr == port_addr))
        |=> st_q.bits[$past(port_addr)] == $past(port_wdata));  // R5

    AST_CONFLICT_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (port_we && err_we && err_addr == port_addr) |=> st_q.bits[$past(port_addr)]);  // R7

    AST_BITS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_we && !err_we) |=> $stable(st_q.bits));  // R6

    AST_READ_OLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd |=> rd_bit == $past(st_q.bits[port_addr]));  // R9

endmodule

// File: rtl/err_log_map.sv
module err_log_map #(
    parameter int SYN_W = elog_pkg::SYN_W_DEF,
    parameter int MSB_W = elog_pkg::MSB_W_DEF,
    localparam int AW   = SYN_W + 1 + MSB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_pulse,
    input  logic [SYN_W-1:0] err_syn,
    input  logic             err_bank,
    input  logic [MSB_W-1:0] err_msb,
    input  logic             rfsh_slot,
    input  logic [AW-1:0]    port_addr,
    input  logic             port_rd,
    input  logic             port_wr,
    input  logic             port_wdata,
    output logic             rd_bit,
    output logic             rd_valid
);

    logic          err_we;
    logic [AW-1:0] err_addr;
    logic          rd_en;
    logic          wr_en;

    elog_addr_form #(.SYN_W(SYN_W), .MSB_W(MSB_W)) u_form (
        .err_pulse (err_pulse),
        .err_syn   (err_syn),
        .err_bank  (err_bank),
        .err_msb   (err_msb),
        .err_we    (err_we),
        .err_addr  (err_addr)
    );

    elog_port_ctl u_ctl (
        .rfsh_slot (rfsh_slot),
        .port_rd   (port_rd),
        .port_wr   (port_wr),
        .rd_en     (rd_en),
        .wr_en     (wr_en)
    );

    elog_array #(.AW(AW)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_we     (err_we),
        .err_addr   (err_addr),
        .port_we    (wr_en),
        .port_rd    (rd_en),
        .port_addr  (port_addr),
        .port_wdata (port_wdata),
        .rd_bit     (rd_bit),
        .rd_valid   (rd_valid)
    );

    AST_RVALID_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rfsh_slot && port_rd));  // R4

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_bit));  // R4

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_slot && port_rd) |=> rd_valid);  // R3

    AST_ERR_ANY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && !rfsh_slot) |=> u_arr.st_q.bits[$past({err_syn, err_bank, err_msb})]);  // R8

endmodule

// File: tb/sim_err_log_map.sv
`timescale 1ns/1ps
module sim_err_log_map;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       err_pulse = 1'b0;
    logic [4:0] err_syn = '0;
    logic       err_bank = 1'b0;
    logic [3:0] err_msb = '0;
    logic       rfsh_slot = 1'b0;
    logic [9:0] port_addr = '0;
    logic       port_rd = 1'b0;
    logic       port_wr = 1'b0;
    logic       port_wdata = 1'b0;
    logic       rd_bit;
    logic       rd_valid;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 0;
    logic mdl [1024];

    always #10 clk = ~clk;  // 50 MHz

    err_log_map u0 (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .err_syn(err_syn),
        .err_bank(err_bank), .err_msb(err_msb), .rfsh_slot(rfsh_slot),
        .port_addr(port_addr), .port_rd(port_rd), .port_wr(port_wr),
        .port_wdata(port_wdata), .rd_bit(rd_bit), .rd_valid(rd_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input int a, input string req, input int exp);
        @(negedge clk);
        rfsh_slot = 1'b1; port_rd = 1'b1; port_wr = 1'b0; port_addr = 10'(a);
        @(negedge clk);
        rfsh_slot = 1'b0; port_rd = 1'b0;
        check({req, " rd_valid"}, int'(rd_valid), 1);
        check({req, " rd_bit"}, int'(rd_bit), exp);
    endtask

    task automatic wr(input int a, input logic v, input logic slot);
        @(negedge clk);
        rfsh_slot = slot; port_wr = 1'b1; port_rd = 1'b0; port_addr = 10'(a); port_wdata = v;
        @(negedge clk);
        rfsh_slot = 1'b0; port_wr = 1'b0;
        if (slot) mdl[a] = v;
    endtask

    task automatic inj(input int s, input int b, input int m);
        @(negedge clk);
        err_pulse = 1'b1; err_syn = 5'(s); err_bank = b[0]; err_msb = 4'(m);
        @(negedge clk);
        err_pulse = 1'b0;
        mdl[s * 32 + b * 16 + m] = 1'b1;
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 1024; a++) rd(a, req, int'(mdl[a]));
    endtask

    initial begin
        for (int a = 0; a < 1024; a++) mdl[a] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 rd_bit", int'(rd_bit), 0);
        sweep("R1 entry");

        // R2 / R8: errors with slot low, index computed arithmetically
        for (int k = 0; k < 32; k++) inj(k, (k ^ (k >> 2)) & 1, (k * 7) % 16);
        inj(3, 1, 15);
        inj(3, 1, 15);  // repeat keeps it at 1
        sweep("R2 R8 map");

        // R4: read request without slot
        rd(0, "R4 setup", int'(mdl[0]));
        begin
            logic prev;
            int   other;
            prev = rd_bit;
            other = 0;
            for (int a = 0; a < 1024; a++) if (mdl[a] != prev) other = a;
            @(negedge clk);
            rfsh_slot = 1'b0; port_rd = 1'b1; port_addr = 10'(other);
            @(negedge clk);
            port_rd = 1'b0;
            check("R4 rd_valid", int'(rd_valid), 0);
            check("R4 rd_bit", int'(rd_bit), int'(prev));
        end

        // R6: write without slot is ignored
        wr(3 * 32 + 16 + 15, 1'b0, 1'b0);
        wr(5, 1'b1, 1'b0);
        rd(3 * 32 + 16 + 15, "R6 kept set", 1);
        rd(5, "R6 kept clear", int'(mdl[5]));

        // R5: clear all, then reload a pattern
        for (int a = 0; a < 1024; a++) wr(a, 1'b0, 1'b1);
        sweep("R5 clear");
        for (int a = 0; a < 1024; a++) wr(a, logic'((a % 3) == 0), 1'b1);
        sweep("R5 reload");

        // R7: conflict, error wins; other-index write still applied
        @(negedge clk);
        err_pulse = 1'b1; err_syn = 5'd9; err_bank = 1'b0; err_msb = 4'd4;  // index 292
        rfsh_slot = 1'b1; port_wr = 1'b1; port_addr = 10'd292; port_wdata = 1'b0;
        @(negedge clk);
        port_addr = 10'd300; port_wdata = 1'b0;  // index 300, pattern value 1
        err_syn = 5'd2; err_bank = 1'b1; err_msb = 4'd1;  // index 81
        @(negedge clk);
        err_pulse = 1'b0; rfsh_slot = 1'b0; port_wr = 1'b0;
        mdl[292] = 1'b1; mdl[300] = 1'b0; mdl[81] = 1'b1;
        rd(292, "R7 err wins", 1);
        rd(300, "R7 other write", 0);
        rd(81, "R7 other err", 1);

        // R9: read and write same index in one slot
        @(negedge clk);
        rfsh_slot = 1'b1; port_rd = 1'b1; port_wr = 1'b1; port_addr = 10'd10; port_wdata = 1'b1;
        @(negedge clk);
        rfsh_slot = 1'b0; port_rd = 1'b0; port_wr = 1'b0;
        check("R9 old value", int'(rd_bit), 0);
        check("R9 rd_valid", int'(rd_valid), 1);
        mdl[10] = 1'b1;
        rd(10, "R9 new value", 1);
        // R3: final full readout
        sweep("R3 final");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule